// File: doc/BRIEF.md
# Dual Segmented Tapped Shift Register

This block holds two independent 64-stage serial shift registers, called channel A and channel B. Each channel is built from four chained 16-stage segments. The junction at the end of each segment is a tap. Every tap has its own output, its own output-enable and its own input. The output and output-enable together model a three-state pin, and the separate input port keeps the design synthesizable. Each channel has its own clock, serial data input, write enable and synchronous clear.

When the write enable is low, the segments form one 64-stage delay line. Data enters at the serial input, and each tap shows the last stage of its segment. All tap output-enables are high in this mode.

When the write enable is high, the taps at the ends of the first three segments turn into entry points for the segments that follow them, and every output-enable drops. The serial input and three tap inputs then fill the four segments at the same time, so a full 64-bit word loads in 16 clocks. The word can then be shifted out serially on the last tap. The last tap has no segment after it, so its input is never used.

Top module: `tapsr_dual`

## Requirements
- R1: When a channel's clear input is high at a rising edge of that channel's clock, all 64 stages of the channel become 0, and every tap output then reads 0.
- R2: At every rising edge, the serial input enters the first stage whatever the write enable is. A bit shows on tap output bit 0 (after stage 16) exactly 16 rising edges later.
- R3: With write enable 0, the segments are chained. A bit taken from the serial input shows on tap output bit k (k = 0..3, after stage 16(k+1)) exactly 16(k+1) rising edges later. The tap inputs have no effect in this mode.
- R4: With write enable 1, tap input bit k (k = 0, 1, 2) feeds the first stage of segment k+1 instead of the last stage of segment k. After 16 loading edges, tap output bit k+1 shows the first bit that was driven on tap input bit k.
- R5: A 64-bit word can be loaded in 16 rising edges: the serial input carries segment 0, and tap inputs 0, 1, 2 carry segments 1, 2, 3. With write enable 0 and 64 further edges, tap output bit 3 then presents the word one bit per cycle, with segment 3's content first and segment 0's content last.
- R6: Tap output-enable is all ones while write enable is 0 and all zeros while write enable is 1. It follows the write enable with no clock edge. Tap outputs keep their register value in both modes.
- R7: Tap input bit 3 never reaches any stage, in either mode.
- R8: The channels are independent. While a channel's clock is idle, its tap outputs hold their values, whatever its own data, tap and write-enable inputs do and whatever the other channel does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_clk | input | 1 | Channel A clock, rising edge active |
| a_clr | input | 1 | Channel A synchronous clear, active high |
| a_sdi | input | 1 | Channel A serial data into stage 1 |
| a_we | input | 1 | Channel A write enable (1 = taps load segments) |
| a_tap_in | input | 4 | Channel A tap inputs; bits 0..2 feed segments 1..3 when loading |
| a_tap_out | output | 4 | Channel A tap outputs, bit k = stage 16(k+1) |
| a_tap_oe | output | 4 | Channel A tap output-enables |
| b_clk | input | 1 | Channel B clock, rising edge active |
| b_clr | input | 1 | Channel B synchronous clear, active high |
| b_sdi | input | 1 | Channel B serial data into stage 1 |
| b_we | input | 1 | Channel B write enable |
| b_tap_in | input | 4 | Channel B tap inputs |
| b_tap_out | output | 4 | Channel B tap outputs |
| b_tap_oe | output | 4 | Channel B tap output-enables |

## Verification
A 64-bit irregular serial pattern is shifted through channel A with write enable low while the tap inputs toggle at random. The bit order and delay seen at the first and last taps separate a correct 16-stage segment from one that is off by a stage, and they also show whether a tap input leaks into the chain. Two parallel words are then loaded, one bit sequence per segment plus random data on the last tap input, and read out serially. A segment swap, a wrong load source or use of the last tap input each gives a distinct wrong sequence on the last tap. Channel B is partly filled and then left with its clock stopped while channel A runs, which separates truly independent channels from shared state.

// File: rtl/tapsr_pkg.sv
package tapsr_pkg;
  localparam int SEG_LEN_DEF = 16;
  localparam int SEG_NUM_DEF = 4;

  typedef enum logic {
    MODE_CHAIN = 1'b0,
    MODE_LOAD  = 1'b1
  } seg_mode_e;
endpackage

// File: rtl/tapsr_segment.sv
module tapsr_segment #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic clr,
  input  logic din,
  output logic dout
);
  localparam int MSB = LEN - 1;

  logic [MSB:0] stg;

  always_ff @(posedge clk) begin
    if (clr) stg <= '0;
    else     stg <= {stg[MSB-1:0], din};
  end

  assign dout = stg[MSB];
endmodule

// File: rtl/tapsr_channel.sv
module tapsr_channel
  import tapsr_pkg::*;
#(
  parameter int SEG_LEN = SEG_LEN_DEF,
  parameter int SEG_NUM = SEG_NUM_DEF
) (
  input  logic               clk,
  input  logic               clr,
  input  logic               sdi,
  input  logic               we,
  input  logic [SEG_NUM-1:0] tap_in,
  output logic [SEG_NUM-1:0] tap_out,
  output logic [SEG_NUM-1:0] tap_oe
);
  seg_mode_e          mode;
  logic [SEG_NUM-1:0] seg_din;
  logic [SEG_NUM-1:0] seg_dout;
  logic               unused_last_tap;

  assign mode            = we ? MODE_LOAD : MODE_CHAIN;
  assign unused_last_tap = tap_in[SEG_NUM-1];

  for (genvar s = 0; s < SEG_NUM; s++) begin : g_seg
    if (s == 0) begin : g_head
      assign seg_din[s] = sdi;
    end else begin : g_body
      assign seg_din[s] = (mode == MODE_LOAD) ? tap_in[s-1] : seg_dout[s-1];
    end

    tapsr_segment #(.LEN(SEG_LEN)) u_seg (
      .clk  (clk),
      .clr  (clr),
      .din  (seg_din[s]),
      .dout (seg_dout[s])
    );
  end

  assign tap_out = seg_dout;
  assign tap_oe  = (mode == MODE_CHAIN) ? '1 : '0;
endmodule

// File: rtl/tapsr_dual.sv
module tapsr_dual
  import tapsr_pkg::*;
#(
  parameter int SEG_LEN = SEG_LEN_DEF,
  parameter int SEG_NUM = SEG_NUM_DEF
) (
  input  logic               a_clk,
  input  logic               a_clr,
  input  logic               a_sdi,
  input  logic               a_we,
  input  logic [SEG_NUM-1:0] a_tap_in,
  output logic [SEG_NUM-1:0] a_tap_out,
  output logic [SEG_NUM-1:0] a_tap_oe,
  input  logic               b_clk,
  input  logic               b_clr,
  input  logic               b_sdi,
  input  logic               b_we,
  input  logic [SEG_NUM-1:0] b_tap_in,
  output logic [SEG_NUM-1:0] b_tap_out,
  output logic [SEG_NUM-1:0] b_tap_oe
);
  tapsr_channel #(.SEG_LEN(SEG_LEN), .SEG_NUM(SEG_NUM)) u_chan_a (
    .clk     (a_clk),
    .clr     (a_clr),
    .sdi     (a_sdi),
    .we      (a_we),
    .tap_in  (a_tap_in),
    .tap_out (a_tap_out),
    .tap_oe  (a_tap_oe)
  );

  tapsr_channel #(.SEG_LEN(SEG_LEN), .SEG_NUM(SEG_NUM)) u_chan_b (
    .clk     (b_clk),
    .clr     (b_clr),
    .sdi     (b_sdi),
    .we      (b_we),
    .tap_in  (b_tap_in),
    .tap_out (b_tap_out),
    .tap_oe  (b_tap_oe)
  );
endmodule

// File: rtl/tapsr_dual_chk.sv
module tapsr_dual_chk #(
  parameter int SEG_NUM = 4
) (
  input logic               a_clk,
  input logic               a_clr,
  input logic               a_sdi,
  input logic               a_we,
  input logic [SEG_NUM-1:0] a_tap_in,
  input logic [SEG_NUM-1:0] a_tap_out,
  input logic [SEG_NUM-1:0] a_tap_oe,
  input logic               b_clk,
  input logic               b_clr,
  input logic               b_sdi,
  input logic               b_we,
  input logic [SEG_NUM-1:0] b_tap_in,
  input logic [SEG_NUM-1:0] b_tap_out,
  input logic [SEG_NUM-1:0] b_tap_oe
);
  // R1
  a_cleared_chk: assert property (@(posedge a_clk) disable iff (a_clr)
    $past(a_clr) |-> (a_tap_out == '0));

  // R1
  b_cleared_chk: assert property (@(posedge b_clk) disable iff (b_clr)
    $past(b_clr) |-> (b_tap_out == '0));

  // R6
  a_oe_drive_chk: assert property (@(posedge a_clk) disable iff (a_clr)
    !a_we |-> (&a_tap_oe));

  // R6
  a_oe_float_chk: assert property (@(posedge a_clk) disable iff (a_clr)
    a_we |-> !(|a_tap_oe));

  // R6
  b_oe_drive_chk: assert property (@(posedge b_clk) disable iff (b_clr)
    !b_we |-> (&b_tap_oe));

  // R6
  b_oe_float_chk: assert property (@(posedge b_clk) disable iff (b_clr)
    b_we |-> !(|b_tap_oe));
endmodule

bind tapsr_dual tapsr_dual_chk #(.SEG_NUM(SEG_NUM)) u_chk (.*);

// File: tb/tapsr_dual_test.sv
module tapsr_dual_test;
  localparam int SEG = 16;

  typedef struct {
    int    cyc;
    int    tap;
    logic  val;
    string req;
  } exp_t;

  logic       a_clk = 0, a_clr = 1, a_sdi = 0, a_we = 0;
  logic [3:0] a_tap_in = '0;
  logic [3:0] a_tap_out, a_tap_oe;
  logic       b_raw = 0, b_run = 1, b_clr = 1, b_sdi = 0, b_we = 0;
  logic [3:0] b_tap_in = '0;
  logic [3:0] b_tap_out, b_tap_oe;
  logic       b_clk;

  int   checks = 0, errors = 0, cyc_a = 0;
  exp_t sb[$];

  assign b_clk = b_raw & b_run;

  always #4 a_clk = ~a_clk;
  initial begin
    #3;
    forever #4 b_raw = ~b_raw;
  end

  tapsr_dual uut (
    .a_clk(a_clk), .a_clr(a_clr), .a_sdi(a_sdi), .a_we(a_we),
    .a_tap_in(a_tap_in), .a_tap_out(a_tap_out), .a_tap_oe(a_tap_oe),
    .b_clk(b_clk), .b_clr(b_clr), .b_sdi(b_sdi), .b_we(b_we),
    .b_tap_in(b_tap_in), .b_tap_out(b_tap_out), .b_tap_oe(b_tap_oe)
  );

  always @(posedge a_clk) cyc_a++;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // monitor: compare scoreboard items due in this cycle
  always @(negedge a_clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].cyc == cyc_a) begin
        chk(sb[i].req, {63'd0, a_tap_out[sb[i].tap]}, {63'd0, sb[i].val});
        sb.delete(i);
      end else if (sb[i].cyc < cyc_a) begin
        chk({sb[i].req, " missed"}, 64'd0, 64'd1);
        sb.delete(i);
      end
    end
  end

  // one channel-A clock with the given inputs; optionally predict the serial path
  task automatic a_step(input logic d, input logic we, input logic [3:0] ti,
                        input bit track, input string req);
    @(negedge a_clk);
    a_sdi = d; a_we = we; a_tap_in = ti;
    if (track)
      for (int k = 0; k < 4; k++) sb.push_back('{cyc_a + SEG*(k+1), k, d, req});
  endtask

  // R4 R5 R7: parallel load over 16 edges, then predictions for the serial readout
  task automatic a_load(input logic [63:0] w);
    int l;
    for (int j = 0; j < SEG; j++) begin
      @(negedge a_clk);
      if (j == 0) begin
        l = cyc_a + SEG;
        for (int k = 0; k < 3; k++) sb.push_back('{l, k, w[(3-k)*SEG], "R4"});
        sb.push_back('{l, 3, w[0], "R7"});
        for (int i = 1; i < 64; i++) sb.push_back('{l + i, 3, w[i], "R5"});
      end
      a_we     = 1'b1;
      a_sdi    = w[48+j];
      a_tap_in = {1'($urandom), w[16+j], w[32+j], w[48-16+j]};
      a_tap_in[0] = w[32+j];
      a_tap_in[1] = w[16+j];
      a_tap_in[2] = w[j];
      #1;
      if (j == 3) chk("R6 oe while loading", {60'd0, a_tap_oe}, 64'h0);
    end
    for (int i = 0; i < 64; i++) a_step(1'b0, 1'b0, 4'h0, 1'b0, "");
    #1 chk("R6 oe while shifting", {60'd0, a_tap_oe}, 64'hF);
  endtask

  initial begin
    repeat (50000) @(posedge a_clk);
    chk("watchdog", 64'd0, 64'd1);
    summary();
    $finish;
  end

  initial begin
    logic [63:0] pat;
    pat = 64'hD6B1_3E05_7C92_48AF;

    // R1: clear both channels
    repeat (3) @(posedge a_clk);
    @(negedge a_clk) a_clr = 0;
    @(negedge b_raw) b_clr = 0;
    #1;
    chk("R1 A taps after clear", {60'd0, a_tap_out}, 64'h0);
    chk("R1 B taps after clear", {60'd0, b_tap_out}, 64'h0);
    chk("R6 A oe idle", {60'd0, a_tap_oe}, 64'hF);

    // R2: 16 ones into B fill segment 0 only
    for (int i = 0; i < SEG; i++) @(negedge b_raw) b_sdi = 1'b1;
    @(negedge b_raw) begin b_sdi = 1'b0; b_run = 1'b0; end
    #1 chk("R2 B first segment full", {60'd0, b_tap_out}, 64'h1);
    // B clock stopped; wiggle its inputs (R8)
    b_sdi = 1'b1; b_tap_in = 4'hB;

    // R2 R3 R7: serial path with random tap inputs while chained
    for (int i = 0; i < 64; i++) a_step(pat[i], 1'b0, 4'($urandom), 1'b1, "R3");
    for (int i = 0; i < 64; i++) a_step(1'b0, 1'b0, 4'($urandom), 1'b0, "");

    // R4 R5 R7: two parallel words
    a_load(64'h0123_4567_89AB_CDEF);
    a_load(64'hFFFF_0000_AAAA_5555);
    #1 chk("R5 scoreboard drained", 64'(sb.size()), 64'd0);

    // R8: B held its contents while A ran
    chk("R8 B taps held", {60'd0, b_tap_out}, 64'h1);
    b_we = 1'b1;
    #1 chk("R6 B oe with we high", {60'd0, b_tap_oe}, 64'h0);
    b_we = 1'b0;
    #1 chk("R8 B taps still held", {60'd0, b_tap_out}, 64'h1);

    // R1: clear A after filling segment 0
    for (int i = 0; i < 20; i++) a_step(1'b1, 1'b0, 4'h0, 1'b0, "");
    #1 chk("R2 A first tap set", {60'd0, a_tap_out}, 64'h1);
    @(negedge a_clk) a_clr = 1'b1;
    @(negedge a_clk) a_clr = 1'b0;
    #1 chk("R1 A cleared after data", {60'd0, a_tap_out}, 64'h0);

    summary();
    $finish;
  end
endmodule